// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block derives the serial clock of an I2C master from the peripheral clock. Software sets a 12-bit divider, a speed mode and a rise-time allowance through a small register port, then sets the enable bit. While enabled, the block repeatedly pulls SCL low for the low time and releases it for the high time. It drives the line only through an open-drain enable (`scl_oe` = 1 pulls the wire low) and reads the wire back on `scl_in`.

There are three timing modes. In standard mode both halves equal the divider. Fast mode with the duty bit clear gives a low half of twice the divider and a high half of one divider. Fast mode with the duty bit set gives a 16:9 low/high ratio. The high half is counted from the moment SCL is released. For up to the rise-time allowance, cycles in which the wire is still low count toward the high time, so a slow bus edge does not lengthen the period. If the wire stays low beyond that allowance, another device is stretching the clock, and the count pauses until the wire reads high. `scl_in` is taken as already synchronous to `clk`. Start and stop generation, data shifting, arbitration and filtering belong to other blocks.

Top module: `scl_clkgen`

## Requirements
- R1: After reset `scl_oe` is 0, and reads return control = 0, divider = 4 and rise allowance = 2. Register addresses are 0 for control, 1 for the divider and 2 for the rise allowance. In the control register, bit 0 is enable, bit 1 is fast mode and bit 2 is the 16:9 duty select.
- R2: In standard mode with divider N, `scl_oe` is 1 for exactly N cycles and then 0 for N cycles, repeating.
- R3: In fast mode with the duty bit 0, the low time is 2·N cycles and the high time is N cycles.
- R4: In fast mode with the duty bit 1, the low time is 16·N cycles and the high time is 9·N cycles.
- R5: A divider write below the minimum stores the minimum. The minimum is 1 when the control register holds fast mode with the duty bit at the time of the write, and 4 otherwise.
- R6: Writes to the divider or the rise allowance while the enable bit is 1 are ignored: the readback and the SCL timing stay unchanged.
- R7: If SCL reads low for d cycles after release and d is no more than the rise allowance A, the high time is unchanged.
- R8: If d > A and A is below the nominal high time H, the high time becomes H + d − A. The generator holds SCL released for that whole time.
- R9: When the enable bit is cleared, `scl_oe` is 0 from the second clock edge after the write and stays 0. After re-enabling, the first low time is a full low time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select (0 control, 1 divider, 2 rise allowance) |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data of the selected register |
| scl_in | input | 1 | Sampled SCL wire level |
| scl_oe | output | 1 | Open-drain enable; 1 pulls SCL low |

## Verification
Each of the three modes is run with random divider values. Comparing the low and high run lengths on `scl_oe` tells the 1:1, 2:1 and 16:9 formulas apart. A bench bus model delays the rising edge of SCL by a random number of cycles against a random rise allowance. Delays inside the allowance must leave the period untouched, and longer delays must add exactly the excess, which separates compensation from stretching. Directed cases cover clamping at both minimums, writes attempted while enabled, and disabling in the middle of a low phase.

// File: rtl/scl_pkg.sv
// Shared types and register encoding for the SCL clock generator.
// Assumes a 2-bit register address and a 3-bit control register.
package scl_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DIV  = 2'd1;
    localparam logic [1:0] ADDR_RISE = 2'd2;

    // Control register, bit 0 = enable, bit 1 = fast, bit 2 = 16:9 duty
    typedef struct packed {
        logic duty;
        logic fast;
        logic en;
    } ctrl_t;

    typedef enum logic [1:0] {
        MODE_STD    = 2'd0,
        MODE_FAST21 = 2'd1,
        MODE_FAST16 = 2'd2
    } speed_mode_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_t;

    // Map control bits to a timing mode; duty matters only in fast mode
    function automatic speed_mode_t mode_of(input ctrl_t c);
        if (!c.fast)
            return MODE_STD;
        else if (c.duty)
            return MODE_FAST16;
        else
            return MODE_FAST21;
    endfunction

endpackage

// File: rtl/scl_cfg_regs.sv
// Configuration registers: control, divider and rise allowance.
// The control register is always writable. The divider and rise allowance
// are locked while enable is set. Divider writes below the mode minimum are
// raised to that minimum, using the mode held in control at write time.
module scl_cfg_regs
    import scl_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int DIV_W        = 12,
    parameter int RISE_W       = 6,
    parameter int DIV_MIN      = 4,
    parameter int DIV_MIN_FAST = 1,
    parameter int RISE_RST     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output logic [DIV_W-1:0]  div_q,
    output logic [RISE_W-1:0] rise_q,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [DIV_W-1:0] MIN_STD  = DIV_W'(DIV_MIN);
    localparam logic [DIV_W-1:0] MIN_FAST = DIV_W'(DIV_MIN_FAST);

    logic [DIV_W-1:0] wr_div;
    logic [DIV_W-1:0] div_floor;
    logic [DIV_W-1:0] div_clamped;
    logic             unused_wdata_hi;

    assign wr_div          = wdata[DIV_W-1:0];
    assign unused_wdata_hi = ^wdata[DATA_W-1:DIV_W];

    // Pick the floor for the divider from the currently held mode
    always_comb begin
        if (mode_of(ctrl_q) == MODE_FAST16)
            div_floor = MIN_FAST;
        else
            div_floor = MIN_STD;
    end

    // Raise a too-small divider value to the floor
    always_comb begin
        div_clamped = (wr_div < div_floor) ? div_floor : wr_div;
    end

    // Register updates with write lock on timing fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            div_q  <= MIN_STD;
            rise_q <= RISE_W'(RISE_RST);
        end else if (wr) begin
            case (addr)
                ADDR_CTRL: ctrl_q <= ctrl_t'(wdata[2:0]);
                ADDR_DIV:  if (!ctrl_q.en) div_q  <= div_clamped;
                ADDR_RISE: if (!ctrl_q.en) rise_q <= wdata[RISE_W-1:0];
                default:   ;
            endcase
        end
    end

    // Read multiplexer
    always_comb begin
        case (addr)
            ADDR_CTRL: rdata = DATA_W'(ctrl_q);
            ADDR_DIV:  rdata = DATA_W'(div_q);
            ADDR_RISE: rdata = DATA_W'(rise_q);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/scl_phase_calc.sv
// Converts divider and speed mode into low and high phase lengths in clock
// cycles. Purely combinational; assumes CNT_W >= DIV_W + 4 so 16*N fits.
module scl_phase_calc
    import scl_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int CNT_W = DIV_W + 4
) (
    input  speed_mode_t      mode,
    input  logic [DIV_W-1:0] div,
    output logic [CNT_W-1:0] low_len,
    output logic [CNT_W-1:0] high_len
);

    logic [CNT_W-1:0] n;

    assign n = CNT_W'(div);

    // Multiply the divider by the mode ratio using shifts and adds
    always_comb begin
        case (mode)
            MODE_FAST21: begin
                low_len  = n << 1;
                high_len = n;
            end
            MODE_FAST16: begin
                low_len  = n << 4;
                high_len = (n << 3) + n;
            end
            default: begin
                low_len  = n;
                high_len = n;
            end
        endcase
    end

endmodule

// File: rtl/scl_phase_fsm.sv
// Low/high phase sequencer that drives the open-drain SCL enable.
// The high count advances while SCL reads high, or while it is still low
// within the rise allowance; otherwise it pauses (clock stretching).
// Assumes scl_in is synchronous to clk and both lengths are at least 1.
module scl_phase_fsm
    import scl_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int RISE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CNT_W-1:0]  low_len,
    input  logic [CNT_W-1:0]  high_len,
    input  logic [RISE_W-1:0] rise_allow,
    input  logic              scl_in,
    output logic              scl_oe,
    output phase_t            phase,
    output logic              stall
);

    logic [CNT_W-1:0]  cnt;
    logic [RISE_W-1:0] rise_cnt;
    logic              seen_high;
    logic              advance;
    logic              low_done;
    logic              high_done;

    // High-phase progress condition
    assign advance   = seen_high | scl_in | (rise_cnt < rise_allow);
    assign stall     = (phase == PH_HIGH) && !advance;
    assign low_done  = cnt >= (low_len - CNT_W'(1));
    assign high_done = cnt >= (high_len - CNT_W'(1));
    assign scl_oe    = (phase == PH_LOW);

    // Phase sequencing and counters; disable acts as a synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            rise_cnt  <= '0;
            seen_high <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    phase <= PH_LOW;
                    cnt   <= '0;
                end
                PH_LOW: begin
                    if (low_done) begin
                        phase     <= PH_HIGH;
                        cnt       <= '0;
                        rise_cnt  <= '0;
                        seen_high <= 1'b0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (scl_in)
                        seen_high <= 1'b1;
                    if (!scl_in && !seen_high && (rise_cnt < rise_allow))
                        rise_cnt <= rise_cnt + RISE_W'(1);
                    if (advance) begin
                        if (high_done) begin
                            phase <= PH_LOW;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/scl_clkgen.sv
// Top level of the SCL clock generator: register port, phase length
// calculation and phase sequencer. SCL leaves only through scl_oe
// (1 = pull low); the wire is read back on scl_in.
module scl_clkgen
    import scl_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int DIV_W        = 12,
    parameter int RISE_W       = 6,
    parameter int DIV_MIN      = 4,
    parameter int DIV_MIN_FAST = 1,
    parameter int RISE_RST     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              scl_in,
    output logic              scl_oe
);

    localparam int CNT_W = DIV_W + 4;

    ctrl_t             ctrl_q;
    logic              ctrl_en;
    logic [DIV_W-1:0]  div_q;
    logic [RISE_W-1:0] rise_q;
    logic [CNT_W-1:0]  low_len;
    logic [CNT_W-1:0]  high_len;
    phase_t            phase;
    logic              stall;

    assign ctrl_en = ctrl_q.en;

    scl_cfg_regs #(
        .DATA_W(DATA_W), .DIV_W(DIV_W), .RISE_W(RISE_W),
        .DIV_MIN(DIV_MIN), .DIV_MIN_FAST(DIV_MIN_FAST), .RISE_RST(RISE_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
        .wdata(cfg_wdata), .ctrl_q(ctrl_q), .div_q(div_q),
        .rise_q(rise_q), .rdata(cfg_rdata)
    );

    scl_phase_calc #(
        .DIV_W(DIV_W), .CNT_W(CNT_W)
    ) u_calc (
        .mode(mode_of(ctrl_q)), .div(div_q),
        .low_len(low_len), .high_len(high_len)
    );

    scl_phase_fsm #(
        .CNT_W(CNT_W), .RISE_W(RISE_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en),
        .low_len(low_len), .high_len(high_len), .rise_allow(rise_q),
        .scl_in(scl_in), .scl_oe(scl_oe), .phase(phase), .stall(stall)
    );

endmodule

// File: rtl/scl_clkgen_sva.sv
// Property checker for scl_clkgen, attached with bind below.
module scl_clkgen_sva
    import scl_pkg::*;
#(
    parameter int DIV_W  = 12,
    parameter int RISE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [1:0]        cfg_addr,
    input logic              ctrl_en,
    input logic [DIV_W-1:0]  div_q,
    input logic [RISE_W-1:0] rise_q,
    input logic              stall,
    input logic              scl_oe
);

    // R9: a cleared enable releases SCL on the next edge
    a_r9_release_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> !scl_oe);

    // R6: divider write while enabled leaves the divider unchanged
    a_r6_div_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && cfg_wr && cfg_addr == ADDR_DIV) |=> $stable(div_q));

    // R6: rise allowance write while enabled leaves it unchanged
    a_r6_rise_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && cfg_wr && cfg_addr == ADDR_RISE) |=> $stable(rise_q));

    // R5: the stored divider never falls below the smallest legal value
    a_r5_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
        div_q != '0);

    // R8: while stretched, SCL stays released on the next cycle
    a_r8_stretch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && ctrl_en) |=> !scl_oe);

    // R1: SCL is released during reset
    a_r1_reset_released: assert property (@(posedge clk)
        !rst_n |=> !scl_oe);

endmodule

bind scl_clkgen scl_clkgen_sva #(
    .DIV_W(DIV_W), .RISE_W(RISE_W)
) u_sva (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .ctrl_en(ctrl_en), .div_q(div_q), .rise_q(rise_q),
    .stall(stall), .scl_oe(scl_oe)
);

// File: tb/scl_clkgen_test.sv
`timescale 1ns/1ps
module scl_clkgen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] cfg_rdata;
    logic        scl_in;
    logic        scl_oe;

    int checks = 0;
    int errors = 0;
    int bus_delay = 0;
    int rel = 0;

    always #2 clk = ~clk;

    scl_clkgen uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .scl_in(scl_in), .scl_oe(scl_oe)
    );

    // Bus model: wire low while driven, rises bus_delay cycles after release
    always @(posedge clk) begin
        if (scl_oe) rel <= 0;
        else if (rel < 1000) rel <= rel + 1;
    end
    assign scl_in = !scl_oe && (rel >= bus_delay);

    function automatic int exp_low(input int mode, input int n);
        if (mode == 1) return 2 * n;
        if (mode == 2) return 16 * n;
        return n;
    endfunction

    function automatic int nom_high(input int mode, input int n);
        if (mode == 2) return 9 * n;
        return n;
    endfunction

    function automatic int exp_high(input int mode, input int n, input int a, input int d);
        int h;
        h = nom_high(mode, n);
        if (a < h && d > a) return h + d - a;
        return h;
    endfunction

    function automatic int ctrl_bits(input int mode);
        if (mode == 1) return 2;
        if (mode == 2) return 6;
        return 0;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        @(negedge clk);
        cfg_addr = a;
        #1;
        d = int'(cfg_rdata);
    endtask

    // Measure one low run and the following high run on scl_oe
    task automatic meas(input bit from_idle, output int lo, output int hi);
        if (!from_idle)
            do @(negedge clk); while (scl_oe);
        do @(negedge clk); while (!scl_oe);
        lo = 0;
        while (scl_oe) begin lo++; @(negedge clk); end
        hi = 0;
        while (!scl_oe) begin hi++; @(negedge clk); end
    endtask

    task automatic configure(input int mode, input int n, input int a, input int d);
        wr(2'd0, ctrl_bits(mode));
        wr(2'd1, n);
        wr(2'd2, a);
        bus_delay = d;
        wr(2'd0, ctrl_bits(mode) | 1);
    endtask

    task automatic run_case(input int mode, input int n, input int a, input int d);
        int lo, hi;
        string tm, tr;
        tm = (mode == 0) ? "R2" : (mode == 1) ? "R3" : "R4";
        tr = (a < nom_high(mode, n) && d > a) ? "R8" : "R7";
        configure(mode, n, a, d);
        meas(1'b1, lo, hi);
        check(tm, "first low", lo, exp_low(mode, n));
        check(tr, "first high", hi, exp_high(mode, n, a, d));
        meas(1'b0, lo, hi);
        check(tm, "steady low", lo, exp_low(mode, n));
        check(tr, "steady high", hi, exp_high(mode, n, a, d));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int v, lo, hi;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1", "scl_oe", int'(scl_oe), 0);
        rd(2'd0, v); check("R1", "ctrl", v, 0);
        rd(2'd1, v); check("R1", "div", v, 4);
        rd(2'd2, v); check("R1", "rise", v, 2);

        // Directed mode checks
        run_case(0, 4, 2, 0);
        run_case(1, 5, 2, 1);
        run_case(2, 1, 0, 0);

        // R7 / R8 directed rise-time cases
        run_case(0, 10, 5, 5);
        run_case(0, 10, 2, 6);
        run_case(0, 4, 6, 8);

        // Random mix
        for (int i = 0; i < 10; i++) begin
            int m, n, a, d;
            m = int'($urandom % 3);
            n = (m == 2) ? 1 + int'($urandom % 4) : 4 + int'($urandom % 12);
            a = int'($urandom % 8);
            d = int'($urandom % 12);
            run_case(m, n, a, d);
        end

        // R5: clamping at both floors
        wr(2'd0, 0);
        bus_delay = 0;
        wr(2'd1, 1); rd(2'd1, v); check("R5", "std floor", v, 4);
        wr(2'd1, 0); rd(2'd1, v); check("R5", "std zero", v, 4);
        wr(2'd0, 6);
        wr(2'd1, 0); rd(2'd1, v); check("R5", "16:9 floor", v, 1);
        wr(2'd1, 3); rd(2'd1, v); check("R5", "16:9 legal", v, 3);

        // R6: locked writes while enabled
        configure(0, 5, 3, 0);
        wr(2'd1, 9);
        wr(2'd2, 10);
        rd(2'd1, v); check("R6", "div readback", v, 5);
        rd(2'd2, v); check("R6", "rise readback", v, 3);
        meas(1'b0, lo, hi);
        check("R6", "low after locked write", lo, 5);
        check("R6", "high after locked write", hi, 5);

        // R9: disable in the middle of a low phase
        do @(negedge clk); while (!scl_oe);
        @(negedge clk);
        wr(2'd0, 0);
        @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            check("R9", "released", int'(scl_oe), 0);
            @(negedge clk);
        end
        wr(2'd0, 1);
        meas(1'b1, lo, hi);
        check("R9", "first low after re-enable", lo, 5);
        check("R9", "first high after re-enable", hi, 5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule